// File: doc/BRIEF.md
# Synchronizable Multi-Channel Clock Divider Bank

This block divides one fast input clock into several slower clocks. An optional shared pre-divider sits ahead of the bank. When it is bypassed, every input clock cycle is a divider tick. Otherwise one tick comes every `prediv_ratio_m1_i + 1` input cycles. Each channel has its own high and low durations, a start level and a phase offset, and drives two copies of the same output. All timing is expressed as clock enables inside the single `clk_i` domain.

An asynchronous `sync_i` request parks the channels. While it is high, every channel that is not excluded holds both outputs at its start level and copies its settings into working registers. When `sync_i` drops, a fixed restart count runs. All parked channels then restart on the same tick, and each one waits its own phase offset before its first transition. This gives a known phase relation between them. A channel with its exclude bit set ignores `sync_i` and keeps clocking. Such a channel picks up new settings at the start of each high phase.

Top module: `syncdiv_bank`

## Requirements
- R1: While `rst_n_i` is low, every output is 0.
- R2: While `sync_i` is held high, each non-excluded channel drives both outputs at its `cfg_start_high_i` bit and keeps them static.
- R3: A channel whose `cfg_nosync_i` bit is 1 keeps toggling while `sync_i` is high.
- R4: Number the first rising edge of `clk_i` after `sync_i` falls as edge 0. With the pre-divider bypassed and phase offset 0, a non-excluded channel's first transition lands on edge `RESTART_TICKS + 1 + C`. Here C is the duration of its first phase, and the outputs stay static before that edge.
- R5: A phase offset P (field of `PH_W` bits at channel c, bits `[c*PH_W +: PH_W]`) delays that first transition by P ticks.
- R6: A running channel is high for `hi_m1 + 1` ticks and low for `lo_m1 + 1` ticks. Each count field is `CNT_W` bits wide at bits `[c*CNT_W +: CNT_W]`, so durations range from 1 to 16.
- R7: After a restart, the first phase is at the start level. If the start bit is 1, C is `hi_m1 + 1`; if it is 0, C is `lo_m1 + 1`.
- R8: With the pre-divider active at ratio N, each tick lasts N input cycles. The first transition then lands on edge `2 + (RESTART_TICKS - 1 + P + C) * N`. Outputs change only on tick cycles unless a sync hold is active.
- R9: For a non-excluded channel, changes to count, phase or start settings made while it runs have no effect until the channel has been parked by a sync hold.
- R10: An excluded channel takes new high and low counts at the start of its next high phase.
- R11: `out_a_o[c]` and `out_b_o[c]` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Asynchronous park/restart request, active high |
| prediv_bypass_i | input | 1 | 1: every input cycle is a tick |
| prediv_ratio_m1_i | input | PRE_W | Pre-divider ratio minus one |
| cfg_hi_m1_i | input | NCH*CNT_W | Per-channel high duration minus one |
| cfg_lo_m1_i | input | NCH*CNT_W | Per-channel low duration minus one |
| cfg_phase_i | input | NCH*PH_W | Per-channel restart delay in ticks |
| cfg_start_high_i | input | NCH | Per-channel parked and first-phase level |
| cfg_nosync_i | input | NCH | Per-channel exclusion from sync |
| out_a_o | output | NCH | First output of each channel |
| out_b_o | output | NCH | Second output of each channel |

## Verification
Each result falls on a known edge. The sync request takes two edges to pass the synchronizer, and the park level appears on the next one. The restart tick comes `RESTART_TICKS - 1` ticks after that. The first transition follows after P + C further ticks, which puts it at sample `3 + (RESTART_TICKS - 1 + P + C) * N` when the bench drops `sync_i` on a falling edge and samples on every later falling edge. The bench computes that sample number and the following edge spacings from its own copy of the settings, then compares them against the recorded edge positions. Pulse widths are counted over a full pulse that starts after a settings change, so a change cannot land part-way through the measured window.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;
  typedef enum logic [1:0] {
    CH_PARK  = 2'd0,
    CH_DELAY = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_e;
endpackage

// File: rtl/syncdiv_front.sv
// Reset release synchronizer and two-flop synchronizer for the sync request.
module syncdiv_front (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sync_i,
  output logic rst_n_o,
  output logic hold_o
);
  logic rst_meta_q;
  logic rst_q;
  logic sync_meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // The request reads as active during reset, so every channel starts parked.
  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      sync_meta_q <= 1'b1;
      sync_q      <= 1'b1;
    end else begin
      sync_meta_q <= sync_i;
      sync_q      <= sync_meta_q;
    end
  end

  assign rst_n_o = rst_q;
  assign hold_o  = sync_q;
endmodule

// File: rtl/syncdiv_prediv.sv
// Shared pre-divider: emits a one-cycle tick every ratio_m1+1 input cycles.
module syncdiv_prediv #(
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             bypass,
  input  logic [PRE_W-1:0] ratio_m1,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] pcnt_d;
  logic             pcnt_en;
  logic             at_zero;

  assign at_zero = (pcnt_q == '0);
  assign tick    = bypass | at_zero;

  always_comb begin
    pcnt_d  = pcnt_q;
    pcnt_en = 1'b1;
    if (hold) begin
      pcnt_d = '0;
    end else if (at_zero) begin
      pcnt_d = ratio_m1;
    end else begin
      pcnt_d = pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/syncdiv_restart.sv
// Counts the fixed restart latency after the sync hold releases.
module syncdiv_restart #(
  parameter int RESTART_TICKS = 12
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  output logic go
);
  localparam int WW = (RESTART_TICKS > 2) ? $clog2(RESTART_TICKS) : 1;
  localparam logic [WW-1:0] WLOAD = WW'(RESTART_TICKS - 1);

  logic          armed_q, armed_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          upd_en;

  assign go     = armed_q & ~hold & tick & (wcnt_q == '0);
  assign upd_en = hold | (armed_q & tick);

  always_comb begin
    armed_d = armed_q;
    wcnt_d  = wcnt_q;
    if (hold) begin
      armed_d = 1'b1;
      wcnt_d  = WLOAD;
    end else if (armed_q && tick) begin
      if (wcnt_q == '0) begin
        armed_d = 1'b0;
      end else begin
        wcnt_d = wcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      wcnt_q  <= WLOAD;
    end else if (upd_en) begin
      armed_q <= armed_d;
      wcnt_q  <= wcnt_d;
    end
  end
endmodule

// File: rtl/syncdiv_chan.sv
// One divider channel with park, phase-delay and run states.
module syncdiv_chan
  import syncdiv_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PH_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             go,
  input  logic             nosync,
  input  logic [CNT_W-1:0] hi_m1,
  input  logic [CNT_W-1:0] lo_m1,
  input  logic [PH_W-1:0]  phase,
  input  logic             start_high,
  output logic             level
);
  localparam int CW = (PH_W > CNT_W) ? PH_W : CNT_W;

  ch_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] w_hi_q, w_hi_d;
  logic [CNT_W-1:0] w_lo_q, w_lo_d;
  logic [PH_W-1:0]  w_ph_q, w_ph_d;
  logic             w_st_q, w_st_d;
  logic             capture;
  logic [CW-1:0]    first_len;

  // Park when a sync applies; a parked channel keeps capturing while held.
  assign capture   = hold & (~nosync | (state_q == CH_PARK));
  assign first_len = w_st_q ? CW'(w_hi_q) : CW'(w_lo_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lvl_d   = lvl_q;
    w_hi_d  = w_hi_q;
    w_lo_d  = w_lo_q;
    w_ph_d  = w_ph_q;
    w_st_d  = w_st_q;
    if (capture) begin
      state_d = CH_PARK;
      cnt_d   = '0;
      lvl_d   = start_high;
      w_hi_d  = hi_m1;
      w_lo_d  = lo_m1;
      w_ph_d  = phase;
      w_st_d  = start_high;
    end else begin
      unique case (state_q)
        CH_PARK: begin
          if (go) begin
            lvl_d = w_st_q;
            if (w_ph_q == '0) begin
              state_d = CH_RUN;
              cnt_d   = first_len;
            end else begin
              state_d = CH_DELAY;
              cnt_d   = CW'(w_ph_q) - 1'b1;
            end
          end
        end
        CH_DELAY: begin
          if (tick) begin
            if (cnt_q == '0) begin
              state_d = CH_RUN;
              cnt_d   = first_len;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        CH_RUN: begin
          if (tick) begin
            if (cnt_q == '0) begin
              lvl_d = ~lvl_q;
              if (!lvl_q) begin
                if (nosync) begin
                  // Excluded channel: settings taken at the high-phase start.
                  w_hi_d = hi_m1;
                  w_lo_d = lo_m1;
                  cnt_d  = CW'(hi_m1);
                end else begin
                  cnt_d = CW'(w_hi_q);
                end
              end else begin
                cnt_d = CW'(w_lo_q);
              end
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: begin
          state_d = CH_PARK;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_PARK;
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      w_hi_q  <= '0;
      w_lo_q  <= '0;
      w_ph_q  <= '0;
      w_st_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lvl_q   <= lvl_d;
      w_hi_q  <= w_hi_d;
      w_lo_q  <= w_lo_d;
      w_ph_q  <= w_ph_d;
      w_st_q  <= w_st_d;
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/syncdiv_bank.sv
module syncdiv_bank #(
  parameter int NCH           = 4,
  parameter int CNT_W         = 4,
  parameter int PH_W          = 5,
  parameter int PRE_W         = 3,
  parameter int RESTART_TICKS = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 sync_i,
  input  logic                 prediv_bypass_i,
  input  logic [PRE_W-1:0]     prediv_ratio_m1_i,
  input  logic [NCH*CNT_W-1:0] cfg_hi_m1_i,
  input  logic [NCH*CNT_W-1:0] cfg_lo_m1_i,
  input  logic [NCH*PH_W-1:0]  cfg_phase_i,
  input  logic [NCH-1:0]       cfg_start_high_i,
  input  logic [NCH-1:0]       cfg_nosync_i,
  output logic [NCH-1:0]       out_a_o,
  output logic [NCH-1:0]       out_b_o
);
  logic           rst_n;
  logic           sync_q;
  logic           tick;
  logic           go;
  logic [NCH-1:0] level;

  syncdiv_front u_front (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .sync_i  (sync_i),
    .rst_n_o (rst_n),
    .hold_o  (sync_q)
  );

  syncdiv_prediv #(.PRE_W(PRE_W)) u_prediv (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .hold     (sync_q),
    .bypass   (prediv_bypass_i),
    .ratio_m1 (prediv_ratio_m1_i),
    .tick     (tick)
  );

  syncdiv_restart #(.RESTART_TICKS(RESTART_TICKS)) u_restart (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .hold  (sync_q),
    .tick  (tick),
    .go    (go)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    syncdiv_chan #(.CNT_W(CNT_W), .PH_W(PH_W)) u_chan (
      .clk_i      (clk_i),
      .rst_n      (rst_n),
      .tick       (tick),
      .hold       (sync_q),
      .go         (go),
      .nosync     (cfg_nosync_i[c]),
      .hi_m1      (cfg_hi_m1_i[c*CNT_W +: CNT_W]),
      .lo_m1      (cfg_lo_m1_i[c*CNT_W +: CNT_W]),
      .phase      (cfg_phase_i[c*PH_W +: PH_W]),
      .start_high (cfg_start_high_i[c]),
      .level      (level[c])
    );
  end

  assign out_a_o = level;
  assign out_b_o = level;
endmodule

// File: rtl/syncdiv_bank_chk.sv
module syncdiv_bank_chk #(
  parameter int NCH     = 4,
  parameter int RESTART = 12
) (
  input logic           clk_i,
  input logic           rst_n_i,
  input logic           rst_n,
  input logic           sync_q,
  input logic           tick,
  input logic [NCH-1:0] nosync,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] out_a
);
  localparam int QW = $clog2(RESTART + 1) + 1;

  logic [QW-1:0]  qcnt_q;
  logic [NCH-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      held_q <= '0;
    end else begin
      if (sync_q) begin
        qcnt_q <= '0;
        held_q <= ~nosync;
      end else if (qcnt_q < QW'(RESTART)) begin
        qcnt_q <= qcnt_q + 1'b1;
      end
    end
  end

  always @(posedge clk_i) begin
    if (!rst_n_i) begin
      // R1
      rst_zero_chk: assert (out_a == '0);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R2
    park_level_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (sync_q && !nosync[g]) |=> (out_a[g] == $past(start[g])));

    // R8
    tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!tick && !sync_q) |=> $stable(out_a[g]));

    // R4
    restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!sync_q && held_q[g] && (qcnt_q < QW'(RESTART))) |=> $stable(out_a[g]));
  end
endmodule

bind syncdiv_bank syncdiv_bank_chk #(.NCH(NCH), .RESTART(RESTART_TICKS)) u_chk (
  .clk_i   (clk_i),
  .rst_n_i (rst_n_i),
  .rst_n   (rst_n),
  .sync_q  (sync_q),
  .tick    (tick),
  .nosync  (cfg_nosync_i),
  .start   (cfg_start_high_i),
  .out_a   (out_a_o)
);

// File: tb/syncdiv_bank_test.sv
`timescale 1ns/1ps
module syncdiv_bank_test;
  localparam int NCH = 4;
  localparam int CNT_W = 4;
  localparam int PH_W = 5;
  localparam int PRE_W = 3;
  localparam int RT = 12;

  logic                 clk = 1'b0;
  logic                 rst_n_i;
  logic                 sync_i;
  logic                 byp;
  logic [PRE_W-1:0]     ratio_m1;
  logic [NCH*CNT_W-1:0] hi_v, lo_v;
  logic [NCH*PH_W-1:0]  ph_v;
  logic [NCH-1:0]       st_v, ns_v;
  logic [NCH-1:0]       out_a, out_b;

  int hi[NCH] = '{2, 3, 0, 1};
  int lo[NCH] = '{1, 3, 4, 1};
  int ph[NCH] = '{0, 3, 5, 2};
  int st[NCH] = '{1, 0, 1, 0};
  int ns[NCH] = '{0, 0, 0, 1};

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  syncdiv_bank #(.NCH(NCH), .CNT_W(CNT_W), .PH_W(PH_W), .PRE_W(PRE_W),
                 .RESTART_TICKS(RT)) uut (
    .clk_i(clk), .rst_n_i(rst_n_i), .sync_i(sync_i),
    .prediv_bypass_i(byp), .prediv_ratio_m1_i(ratio_m1),
    .cfg_hi_m1_i(hi_v), .cfg_lo_m1_i(lo_v), .cfg_phase_i(ph_v),
    .cfg_start_high_i(st_v), .cfg_nosync_i(ns_v),
    .out_a_o(out_a), .out_b_o(out_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int c = 0; c < NCH; c++) begin
      hi_v[c*CNT_W +: CNT_W] = CNT_W'(hi[c]);
      lo_v[c*CNT_W +: CNT_W] = CNT_W'(lo[c]);
      ph_v[c*PH_W +: PH_W]   = PH_W'(ph[c]);
      st_v[c] = st[c][0];
      ns_v[c] = ns[c][0];
    end
  endtask

  // R1: outputs low during reset
  task automatic t_reset();
    rst_n_i = 1'b0;
    sync_i  = 1'b1;
    byp     = 1'b1;
    ratio_m1 = '0;
    apply_cfg();
    repeat (5) @(negedge clk);
    chk(out_a == '0 && out_b == '0, "R1 reset outputs", int'(out_a), 0);
    rst_n_i = 1'b1;
  endtask

  // R2/R7: parked at start level while sync held
  task automatic t_hold();
    int moved = 0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        if (ns[c] == 0 && out_a[c] !== st[c][0]) moved++;
    end
    for (int c = 0; c < NCH; c++)
      if (ns[c] == 0)
        chk(out_a[c] == st[c][0] && out_b[c] == st[c][0], "R2 parked level", int'(out_a[c]), st[c]);
    chk(moved == 0, "R2 static while held", moved, 0);
  endtask

  // R4/R5/R6/R7/R8/R11: restart timing, first edges and phase lengths
  task automatic t_restart(input int nrat, input string tag);
    int tc[NCH][3];
    int nchg[NCH];
    int pair_bad = 0;
    logic [NCH-1:0] prev;
    for (int c = 0; c < NCH; c++) begin
      nchg[c] = 0;
      for (int j = 0; j < 3; j++) tc[c][j] = -1;
    end
    @(negedge clk);
    prev = out_a;
    sync_i = 1'b0;
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk);
      if (out_a != out_b) pair_bad++;
      for (int c = 0; c < NCH; c++)
        if (out_a[c] != prev[c]) begin
          if (nchg[c] < 3) tc[c][nchg[c]] = n;
          nchg[c]++;
          prev[c] = out_a[c];
        end
    end
    for (int c = 0; c < NCH; c++) begin
      if (ns[c] == 0) begin
        int cf = (st[c] != 0) ? hi[c] + 1 : lo[c] + 1;
        int cs = (st[c] != 0) ? lo[c] + 1 : hi[c] + 1;
        int e1 = 3 + (RT - 1 + ph[c] + cf) * nrat;
        chk(tc[c][0] == e1, (ph[c] == 0) ? {tag, " R4 R7 first edge"} : {tag, " R5 R7 phase first edge"},
            tc[c][0], e1);
        chk(tc[c][1] - tc[c][0] == cs * nrat, {tag, " R6 second phase"}, tc[c][1] - tc[c][0], cs * nrat);
        chk(tc[c][2] - tc[c][1] == cf * nrat, {tag, " R6 third phase"}, tc[c][2] - tc[c][1], cf * nrat);
      end
    end
    chk(pair_bad == 0, {tag, " R11 pair equal"}, pair_bad, 0);
  endtask

  // R2/R3: held channels static, excluded channel toggles
  task automatic t_nosync();
    int tog = 0;
    int moved = 0;
    logic [NCH-1:0] prev;
    @(negedge clk);
    sync_i = 1'b1;
    repeat (5) @(negedge clk);
    prev = out_a;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (out_a[c] != prev[c]) begin
          if (ns[c] != 0) tog++;
          else moved++;
        end
      end
      prev = out_a;
    end
    chk(moved == 0, "R2 held during sync", moved, 0);
    for (int c = 0; c < NCH; c++)
      if (ns[c] == 0) chk(out_a[c] == st[c][0], "R2 held level", int'(out_a[c]), st[c]);
    chk(tog >= 8, "R3 excluded channel toggles", tog, 8);
  endtask

  task automatic measure_pulse(input int c, input logic lvl, output int len);
    int guard = 0;
    len = 0;
    while (out_a[c] == lvl && guard < 500) begin @(negedge clk); guard++; end
    while (out_a[c] != lvl && guard < 500) begin @(negedge clk); guard++; end
    while (out_a[c] == lvl && guard < 500) begin @(negedge clk); guard++; len++; end
  endtask

  // R9: running channel ignores new settings
  task automatic t_shadow(input int nrat);
    int len;
    int old_lo = lo[1];
    lo[1] = 6;
    ph[1] = 9;
    apply_cfg();
    measure_pulse(1, 1'b0, len);
    chk(len == (old_lo + 1) * nrat, "R9 running ignores config", len, (old_lo + 1) * nrat);
    measure_pulse(1, 1'b0, len);
    chk(len == (old_lo + 1) * nrat, "R9 still old low length", len, (old_lo + 1) * nrat);
  endtask

  // R10: excluded channel takes new counts at high-phase start
  task automatic t_nosync_update(input int nrat);
    int len;
    hi[3] = 4;
    apply_cfg();
    repeat (40) @(negedge clk);
    measure_pulse(3, 1'b1, len);
    chk(len == (hi[3] + 1) * nrat, "R10 excluded new high", len, (hi[3] + 1) * nrat);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_restart(1, "bypass");
    t_nosync();
    // settings changed while held, pre-divider enabled at ratio 3
    hi[0] = 4;
    apply_cfg();
    byp = 1'b0;
    ratio_m1 = 3'd2;
    repeat (4) @(negedge clk);
    t_restart(3, "R8 prediv");
    t_shadow(3);
    t_nosync_update(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule